// File: doc/BRIEF.md
# Pipelined Narrow Floating-Point Adder

This block adds two 27-bit floating-point numbers and returns their 27-bit sum two clock cycles later. The word is a reduced-width relative of the usual single-precision layout, sized for parallel DSP datapaths where dynamic range matters more than strict conformance. There are no NaNs, infinities, denormals or rounding modes. Any operand whose exponent field is zero counts as zero. Fractions are truncated.

The first stage orders the operands by magnitude and shifts the smaller mantissa right to line it up with the larger one. The second stage adds or subtracts the mantissas according to the signs, then renormalises with a leading-zero count and adjusts the exponent. When subtracting two nearly equal values drives the exponent below one, the block flushes the result to positive zero and never emits a garbage word.

Operands arrive on a valid/ready stream and sums leave on another. The two stages advance together. When `out_ready` is high the pipeline accepts one pair per cycle. When a result is held with `out_ready` low, the whole pipeline freezes: `in_ready` drops and the held sum stays put until it is taken.

Top module: `fpadd_pipe`

## Requirements
- R1: Word layout is sign in bit 26, exponent in bits 25:18 with bias 127, and fraction in bits 17:0 under an implied leading one. An operand with exponent field zero acts as zero whatever its fraction and sign, so x + zero returns x unchanged.
- R2: With `out_ready` held high, a pair accepted on one clock edge produces its sum with `out_valid` high after the second following edge, and a new pair can be accepted every cycle.
- R3: Operands of equal sign add their mantissas. A carry out raises the exponent by one and shifts the mantissa right one place, dropping the low bit.
- R4: Operands of differing sign subtract the smaller magnitude from the larger, and the result takes the sign of the larger-magnitude operand.
- R5: When the exponent gap is 19 or more, the smaller operand contributes nothing and the larger operand is returned bit for bit. A gap of 18 still contributes its leading one.
- R6: Mantissa bits shifted out during alignment are discarded before the add or subtract (truncation, no rounding).
- R7: After cancellation the result is shifted left until its leading one reaches the hidden position, and the exponent drops by the shift amount. If that exponent would fall below 1, the output is all-zero.
- R8: A zero mantissa result (exact cancellation or two zero operands) gives the all-zero word, that is, positive zero.
- R9: While `out_valid` is high and `out_ready` low, `out_sum` and `out_valid` hold their values and `in_ready` is low.
- R10: During reset `out_valid` is 0 and `out_sum` is 0.
- R11: Cycles with `in_valid` low create bubbles that produce no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| in_a | input | 27 | First operand |
| in_b | input | 27 | Second operand |
| out_valid | output | 1 | Sum present |
| out_ready | input | 1 | Consumer takes the sum this cycle |
| out_sum | output | 27 | Sum of the pair |

## Verification
The assertions assume that operand exponents stay at or below 253. Exponent overflow on a carry is not detected, so an exponent of 255 that gains one would wrap. The stimulus therefore keeps every nonzero exponent between 1 and 253. It also includes a share of zero-exponent operands, near-equal pairs at both mid-range and very small exponents, and alignment gaps of exactly 18 and 19. In the second half of the run, `out_ready` is withheld at random to exercise the freeze behaviour.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  // Default field widths of the narrow float word.
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 18;

  // Mantissa operation chosen from the operand signs.
  typedef enum logic {
    MOP_ADD = 1'b0,
    MOP_SUB = 1'b1
  } mant_op_e;

endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter  int W  = 19,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  // Scan upward; the highest set bit wins the last assignment.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter  int EXP_W  = FP_EXP_W,
  parameter  int FRAC_W = FP_FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              al_valid,
  output logic              al_sign,
  output logic [EXP_W-1:0]  al_exp,
  output logic [MANT_W-1:0] al_mbig,
  output logic [MANT_W-1:0] al_msmall,
  output mant_op_e          al_op
);

  localparam int MAG_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_a, exp_b, exp_big, exp_small, gap;
  logic              zero_a, zero_b, a_first, sign_big;
  logic [MAG_W-1:0]  mag_a, mag_b;
  logic [MANT_W-1:0] man_a, man_b, man_big, man_small, man_shift;

  always_comb begin
    exp_a  = in_a[WORD_W-2 -: EXP_W];
    exp_b  = in_b[WORD_W-2 -: EXP_W];
    zero_a = (exp_a == '0);
    zero_b = (exp_b == '0);
    mag_a  = zero_a ? '0 : in_a[MAG_W-1:0];
    mag_b  = zero_b ? '0 : in_b[MAG_W-1:0];
    man_a  = zero_a ? '0 : {1'b1, in_a[FRAC_W-1:0]};
    man_b  = zero_b ? '0 : {1'b1, in_b[FRAC_W-1:0]};

    a_first   = (mag_a >= mag_b);
    sign_big  = a_first ? in_a[WORD_W-1] : in_b[WORD_W-1];
    exp_big   = a_first ? exp_a : exp_b;
    exp_small = a_first ? exp_b : exp_a;
    man_big   = a_first ? man_a : man_b;
    man_small = a_first ? man_b : man_a;

    gap = exp_big - exp_small;
    if (gap >= EXP_W'(MANT_W)) man_shift = '0;
    else                       man_shift = man_small >> gap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_valid  <= 1'b0;
      al_sign   <= 1'b0;
      al_exp    <= '0;
      al_mbig   <= '0;
      al_msmall <= '0;
      al_op     <= MOP_ADD;
    end else if (en) begin
      al_valid  <= in_valid;
      al_sign   <= sign_big;
      al_exp    <= exp_big;
      al_mbig   <= man_big;
      al_msmall <= man_shift;
      al_op     <= (in_a[WORD_W-1] ^ in_b[WORD_W-1]) ? MOP_SUB : MOP_ADD;
    end
  end

  // R4
  mag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_valid |-> (al_mbig >= al_msmall));

  // R1
  zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_valid && al_mbig == '0) |-> (al_msmall == '0 && al_exp == '0));

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
#(
  parameter  int EXP_W  = FP_EXP_W,
  parameter  int FRAC_W = FP_FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int CW     = $clog2(MANT_W + 1),
  localparam int EW2    = EXP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              al_valid,
  input  logic              al_sign,
  input  logic [EXP_W-1:0]  al_exp,
  input  logic [MANT_W-1:0] al_mbig,
  input  logic [MANT_W-1:0] al_msmall,
  input  mant_op_e          al_op,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_sum
);

  logic [MANT_W:0]   raw;
  logic [CW-1:0]     lead;
  logic [MANT_W-1:0] nmant;
  logic [EXP_W-1:0]  nexp;
  logic              res_zero;
  logic [WORD_W-1:0] result;

  always_comb begin
    if (al_op == MOP_SUB) raw = {1'b0, al_mbig} - {1'b0, al_msmall};
    else                  raw = {1'b0, al_mbig} + {1'b0, al_msmall};
  end

  fpadd_lzc #(.W(MANT_W)) u_lzc (
    .vec   (raw[MANT_W-1:0]),
    .zeros (lead)
  );

  always_comb begin
    res_zero = 1'b0;
    nmant    = '0;
    nexp     = al_exp;
    if (raw == '0) begin
      res_zero = 1'b1;
    end else if (raw[MANT_W]) begin
      nmant = raw[MANT_W:1];
      nexp  = al_exp + EXP_W'(1);
    end else begin
      nmant = raw[MANT_W-1:0] << lead;
      nexp  = al_exp - EXP_W'(lead);
      if (EW2'(al_exp) <= EW2'(lead)) res_zero = 1'b1;
    end
    result = res_zero ? '0 : {al_sign, nexp, nmant[FRAC_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (en) begin
      out_valid <= al_valid;
      out_sum   <= result;
    end
  end

  // R7
  lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_valid && !res_zero) |-> nmant[MANT_W-1]);

  // R8
  zero_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sum[WORD_W-2 -: EXP_W] == '0) |-> (out_sum == '0));

endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter  int EXP_W  = FP_EXP_W,
  parameter  int FRAC_W = FP_FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_sum
);

  logic              adv;
  logic              al_valid, al_sign;
  logic [EXP_W-1:0]  al_exp;
  logic [MANT_W-1:0] al_mbig, al_msmall;
  mant_op_e          al_op;

  // Both stages move together; a held result freezes the pipe.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .al_valid  (al_valid),
    .al_sign   (al_sign),
    .al_exp    (al_exp),
    .al_mbig   (al_mbig),
    .al_msmall (al_msmall),
    .al_op     (al_op)
  );

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .al_valid  (al_valid),
    .al_sign   (al_sign),
    .al_exp    (al_exp),
    .al_mbig   (al_mbig),
    .al_msmall (al_msmall),
    .al_op     (al_op),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // R11
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) ##1 in_ready |=> !out_valid);

endmodule

// File: tb/test_fpadd_pipe.sv
module test_fpadd_pipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [26:0] in_a = '0;
  logic [26:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [26:0] out_sum;

  always #10 clk = ~clk;

  fpadd_pipe i_fpadd_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sum   (out_sum)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit lat_mode = 1'b1;
  bit prev_stall = 1'b0;
  logic [26:0] prev_sum = '0;

  logic [26:0] exp_q[$];
  string       tag_q[$];
  int          cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [26:0] mk(bit s, int e, int f);
    return {s, 8'(e), 18'(f)};
  endfunction

  // Behavioural reference from the requirements (integer arithmetic).
  function automatic logic [26:0] ref_add(logic [26:0] a, logic [26:0] b);
    int ea = int'(a[25:18]);
    int eb = int'(b[25:18]);
    int ka = (ea == 0) ? 0 : int'(a[25:0]);
    int kb = (eb == 0) ? 0 : int'(b[25:0]);
    int ma = (ea == 0) ? 0 : (262144 + int'(a[17:0]));
    int mb = (eb == 0) ? 0 : (262144 + int'(b[17:0]));
    int eg, es, mg, ms, d, s, e;
    bit sg;
    if (ka >= kb) begin eg = ea; es = ea == 0 ? 0 : eb; mg = ma; ms = mb; sg = a[26]; es = eb; end
    else          begin eg = eb; mg = mb; ms = ma; sg = b[26]; es = ea; end
    d = eg - es;
    if (d >= 19) ms = 0;
    else         ms = ms >> d;
    s = (a[26] == b[26]) ? (mg + ms) : (mg - ms);
    if (s == 0) return '0;
    e = eg;
    if (s >= 524288) begin
      s = s >> 1;
      e = e + 1;
    end else begin
      while (s < 262144) begin
        s = s << 1;
        e = e - 1;
      end
    end
    if (e < 1) return '0;
    return {sg, 8'(e), 18'(s)};
  endfunction

  task automatic chk(bit ok, string req, logic [26:0] act, logic [26:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // One cycle: drive at the falling edge, then judge both handshakes.
  task automatic step(bit v, logic [26:0] a, logic [26:0] b, bit ordy,
                      logic [26:0] expv, string tag);
    @(negedge clk);
    in_valid  = v;
    in_a      = a;
    in_b      = b;
    out_ready = ordy;
    #1;
    if (prev_stall)
      chk(out_valid && out_sum == prev_sum, "R9 hold", out_sum, prev_sum);
    prev_stall = out_valid && !out_ready;
    prev_sum   = out_sum;
    if (prev_stall) chk(!in_ready, "R9 in_ready", {26'd0, in_ready}, '0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected beat", out_sum, '0);
      end else begin
        automatic logic [26:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int c = cyc_q.pop_front();
        chk(out_sum == e, t, out_sum, e);
        if (lat_mode) chk(cyc - c == 2, "R2 latency", 27'(cyc - c), 27'd2);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
    end
  endtask

  task automatic send(logic [26:0] a, logic [26:0] b, logic [26:0] expv, string tag);
    step(1'b1, a, b, 1'b1, expv, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b1, '0, "idle");
  endtask

  function automatic logic [26:0] rnd_word(int mode);
    int e = 1 + int'($urandom_range(252));
    return {1'(($urandom)), 8'(e), 18'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    // R10 reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_sum == '0, "R10 reset", out_sum, '0);
    end
    rst_n = 1'b1;

    // R3 same-sign add and carry
    send(mk(0,127,0), mk(0,127,0), mk(0,128,0), "R3 1+1");
    send(mk(0,127,131072), mk(0,127,131072), mk(0,128,131072), "R3 1.5+1.5");
    send(mk(1,127,1), mk(1,127,0), mk(1,128,0), "R3 carry truncation");
    // R4 differing signs
    send(mk(0,128,131072), mk(1,127,0), mk(0,128,0), "R4 3-1");
    send(mk(1,128,131072), mk(0,127,0), mk(1,128,0), "R4 -3+1");
    send(mk(0,127,0), mk(1,128,131072), mk(1,128,0), "R4 1-3");
    // R5 alignment gap boundary
    send(mk(0,150,5), mk(0,131,262143), mk(0,150,5), "R5 gap 19");
    send(mk(1,131,262143), mk(0,150,5), mk(0,150,5), "R5 gap 19 swapped");
    send(mk(0,150,5), mk(0,132,262143), mk(0,150,6), "R5 gap 18");
    // R6 truncated alignment
    send(mk(0,127,0), mk(0,126,1), mk(0,127,131072), "R6 shifted-out bit");
    // R7 cancellation and underflow
    send(mk(0,127,1), mk(1,127,0), mk(0,109,0), "R7 renormalise");
    send(mk(0,19,1), mk(1,19,0), mk(0,1,0), "R7 exponent reaches 1");
    send(mk(0,18,1), mk(1,18,0), '0, "R7 underflow flush");
    send(mk(0,5,1), mk(1,5,0), '0, "R7 deep underflow");
    // R8 exact cancellation
    send(mk(0,100,123), mk(1,100,123), '0, "R8 x-x");
    send(mk(1,100,123), mk(0,100,123), '0, "R8 -x+x");
    // R1 zero-exponent operand
    send(mk(0,0,4660), mk(1,130,7), mk(1,130,7), "R1 zero plus x");
    send(mk(1,200,99), mk(1,0,262143), mk(1,200,99), "R1 x plus zero");
    send(mk(1,0,5), mk(0,0,9), '0, "R1 zero plus zero");
    // R11 bubbles
    idle(4);
    chk(out_valid == 1'b0, "R11 idle", {26'd0, out_valid}, '0);
    step(1'b1, mk(0,127,0), mk(0,127,0), 1'b1, mk(0,128,0), "R11 after bubble");
    step(1'b0, '0, '0, 1'b1, '0, "idle");
    step(1'b1, mk(0,130,0), mk(1,129,0), 1'b1, mk(0,129,0), "R11 gap pattern");

    // R2 back-to-back random with model, ready always high
    for (int i = 0; i < 1500; i++) begin
      automatic logic [26:0] a = rnd_word(0);
      automatic logic [26:0] b;
      automatic int m = int'($urandom_range(3));
      if (m == 0) b = rnd_word(0);
      else if (m == 1) b = {~a[26], a[25:18], a[17:0] ^ 18'($urandom_range(63))};
      else if (m == 2) begin
        a = {a[26], 8'($urandom_range(24, 1)), a[17:0]};
        b = {~a[26], a[25:18], a[17:0] ^ 18'($urandom_range(255))};
      end else b = {a[26], 8'd0, 18'($urandom)};
      send(a, b, ref_add(a, b), "R4 R7 random model");
    end

    // R9 random back-pressure with model
    lat_mode = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      automatic logic [26:0] a = rnd_word(0);
      automatic logic [26:0] b = (i % 3 == 0) ? {~a[26], a[25:18], a[17:0] ^ 18'($urandom_range(15))}
                                               : rnd_word(0);
      step(1'($urandom_range(1)), a, b, ($urandom_range(3) != 0), ref_add(a, b), "R9 stream model");
    end
    idle(6);
    chk(exp_q.size() == 0, "R2 all results drained", 27'(exp_q.size()), '0);
    chk(out_valid == 1'b0, "R11 final idle", {26'd0, out_valid}, '0);
    finish_run();
  end

endmodule